// File: doc/BRIEF.md
# Shared-Unit Quadratic Evaluator

This block evaluates y = A·x² + B·x + C with a single multiplier and a single adder. A five-state controller reuses both units across consecutive cycles. Operand multiplexers route the input value, the stored square and the coefficients into the multiplier. A second multiplexer chooses the adder's other operand. Working registers carry the intermediate values from one step to the next. All arithmetic is two's complement and is truncated to the data width, so the result is the exact polynomial taken modulo 2^W.

To start a computation, a caller drives the coefficients and x, then pulses or holds `go` while the block is idle. The value of x is captured on that edge. The coefficients are read during the later steps, so the caller must hold them stable until `done` is seen. The result appears on `y_out` together with a one-cycle `done` pulse and stays there until the next result is written. A reset synchronizer inside the block asserts reset at once and releases it on the clock.

Top module: `quad_eval_fsmd`

## Requirements
- R1: While reset is active and after it is released, `done` is 0 and `y_out` is 0 until the first computation completes.
- R2: When `go` is sampled high in the idle state, the next result equals (A·x² + B·x + C) mod 2^W. The operands are W-bit two's-complement values, and every intermediate product and sum is truncated to W bits.
- R3: `done` goes high for exactly one cycle, at the fifth rising edge when the edge that samples `go` is counted as the first.
- R4: If `go` is asserted while a computation is in progress, it is ignored. The computation in flight is neither restarted nor extended, and no extra result is produced.
- R5: `y_out` changes only on the edge that raises `done`, and otherwise holds the last result.
- R6: `x_in` is captured on the edge that samples `go`. Changes to `x_in` after that edge do not affect the result.
- R7: With `go` held high, a new computation starts in the cycle where `done` is high. Results then follow one another every five cycles.
- R8: One multiplier forms x·x, then B·x, then A·x², in that order of steps. One adder forms B·x + C and then the final sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start request, accepted only when idle |
| x_in | input | W | Value at which the polynomial is evaluated |
| coef_a | input | W | Square-term coefficient, held until done |
| coef_b | input | W | Linear-term coefficient, held until done |
| coef_c | input | W | Constant term, held until done |
| y_out | output | W | Registered result |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The bench targets truncation corners: x² wrapping to zero or to one, negative coefficients and arguments, and sums that wrap across the sign boundary. A design that kept extra product bits, or that let the adder see an unregistered product, would give a wrong value on these. It issues `go` in the middle of a run and changes `x_in` after the start edge. A controller that restarted on the stray request, or a datapath that read x live, would produce a second pulse or a result that mixes two arguments. Holding `go` high checks the five-cycle repeat rate, which a design with an extra idle cycle would miss.

// File: rtl/quad_pkg.sv
package quad_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SQ   = 3'd1,
    ST_BX   = 3'd2,
    ST_LIN  = 3'd3,
    ST_FIN  = 3'd4
  } qstate_t;

  typedef enum logic {
    MA_X  = 1'b0,
    MA_XX = 1'b1
  } ma_sel_t;

  typedef enum logic [1:0] {
    MB_X = 2'd0,
    MB_A = 2'd1,
    MB_B = 2'd2
  } mb_sel_t;

  typedef enum logic {
    AD_C   = 1'b0,
    AD_LIN = 1'b1
  } ad_sel_t;

  typedef struct packed {
    ma_sel_t ma;
    mb_sel_t mb;
    ad_sel_t ad;
    logic    ld_x;
    logic    ld_xx;
    logic    ld_prod;
    logic    ld_lin;
    logic    ld_y;
  } ctl_t;

endpackage

// File: rtl/quad_ctrl.sv
module quad_ctrl
  import quad_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    go,
  output qstate_t state,
  output ctl_t    ctl,
  output logic    done
);

  qstate_t state_d;

  always_comb begin
    state_d     = state;
    ctl         = '0;
    ctl.ma      = MA_X;
    ctl.mb      = MB_X;
    ctl.ad      = AD_C;
    unique case (state)
      ST_IDLE: begin
        if (go) begin
          ctl.ld_x = 1'b1;
          state_d  = ST_SQ;
        end
      end
      ST_SQ: begin
        ctl.ma    = MA_X;
        ctl.mb    = MB_X;
        ctl.ld_xx = 1'b1;
        state_d   = ST_BX;
      end
      ST_BX: begin
        ctl.ma      = MA_X;
        ctl.mb      = MB_B;
        ctl.ld_prod = 1'b1;
        state_d     = ST_LIN;
      end
      ST_LIN: begin
        ctl.ad      = AD_C;
        ctl.ld_lin  = 1'b1;
        ctl.ma      = MA_XX;
        ctl.mb      = MB_A;
        ctl.ld_prod = 1'b1;
        state_d     = ST_FIN;
      end
      ST_FIN: begin
        ctl.ad   = AD_LIN;
        ctl.ld_y = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_d;
      done  <= ctl.ld_y;
    end
  end

endmodule

// File: rtl/quad_dpath.sv
module quad_dpath
  import quad_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctl_t         ctl,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] coef_a,
  input  logic [W-1:0] coef_b,
  input  logic [W-1:0] coef_c,
  output logic [W-1:0] y_q
);

  logic [W-1:0] x_q, xx_q, prod_q, lin_q;
  logic [W-1:0] op_a, op_b, mul_out;
  logic [W-1:0] add_other, add_out;

  // multiplier operand steering
  always_comb begin
    op_a = (ctl.ma == MA_XX) ? xx_q : x_q;
    unique case (ctl.mb)
      MB_A:    op_b = coef_a;
      MB_B:    op_b = coef_b;
      default: op_b = x_q;
    endcase
  end

  assign mul_out = op_a * op_b;

  // adder: one input is always the registered product
  assign add_other = (ctl.ad == AD_LIN) ? lin_q : coef_c;
  assign add_out   = prod_q + add_other;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      xx_q   <= '0;
      prod_q <= '0;
      lin_q  <= '0;
      y_q    <= '0;
    end else begin
      if (ctl.ld_x)    x_q    <= x_in;
      if (ctl.ld_xx)   xx_q   <= mul_out;
      if (ctl.ld_prod) prod_q <= mul_out;
      if (ctl.ld_lin)  lin_q  <= add_out;
      if (ctl.ld_y)    y_q    <= add_out;
    end
  end

endmodule

// File: rtl/quad_eval_fsmd.sv
module quad_eval_fsmd
  import quad_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] coef_a,
  input  logic [W-1:0] coef_b,
  input  logic [W-1:0] coef_c,
  output logic [W-1:0] y_out,
  output logic         done
);

  logic    rst_meta_n, rst_q_n;
  qstate_t state;
  ctl_t    ctl;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  quad_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_q_n),
    .go    (go),
    .state (state),
    .ctl   (ctl),
    .done  (done)
  );

  quad_dpath #(.W(W)) u_dpath (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .ctl    (ctl),
    .x_in   (x_in),
    .coef_a (coef_a),
    .coef_b (coef_b),
    .coef_c (coef_c),
    .y_q    (y_out)
  );

endmodule

// File: rtl/quad_eval_chk.sv
module quad_eval_chk
  import quad_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_q_n,
  input logic         go,
  input qstate_t      state,
  input logic         done,
  input logic [W-1:0] y
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_q_n |-> (!done && y == '0));

  assert_go_latency_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state == ST_IDLE && go) |-> ##5 done);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    done |=> !done);

  assert_busy_no_abort_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state != ST_IDLE && state != ST_FIN) |=> (state != ST_IDLE));

  assert_y_hold_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$stable(y) |-> done);

  assert_schedule_order_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state == ST_BX) |=> (state == ST_LIN));

endmodule

bind quad_eval_fsmd quad_eval_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .go      (go),
  .state   (state),
  .done    (done),
  .y       (y_out)
);

// File: tb/quad_eval_fsmd_tb.sv
module quad_eval_fsmd_tb;

  localparam int W = 8;

  typedef struct packed {
    logic [7:0] a, b, c, x, e;
  } vec_t;

  // a, b, c, x, expected y (mod 256)
  localparam vec_t VEC [10] = '{
    '{8'd1,   8'd2,   8'd3,   8'd4,   8'd27},
    '{8'd0,   8'd0,   8'd0,   8'd0,   8'd0},
    '{8'd0,   8'd0,   8'd5,   8'd9,   8'd5},
    '{8'd2,   8'd3,   8'd1,   8'd0,   8'd1},
    '{8'd1,   8'd0,   8'd0,   8'd16,  8'd0},
    '{8'd255, 8'd0,   8'd0,   8'd3,   8'd247},
    '{8'd3,   8'd255, 8'd7,   8'd255, 8'd11},
    '{8'd127, 8'd127, 8'd127, 8'd127, 8'd255},
    '{8'd128, 8'd1,   8'd0,   8'd2,   8'd2},
    '{8'd5,   8'd7,   8'd200, 8'd10,  8'd2}
  };

  logic         clk, rst_n, go, done;
  logic [W-1:0] x_in, coef_a, coef_b, coef_c, y_out;
  int n_chk, n_fail;
  bit finished;

  quad_eval_fsmd #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .go(go), .x_in(x_in),
    .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
    .y_out(y_out), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] model(logic [7:0] a, logic [7:0] b,
                                       logic [7:0] c, logic [7:0] x);
    int unsigned t;
    t = int'(a) * int'(x) * int'(x) + int'(b) * int'(x) + int'(c);
    return t[7:0];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // start one computation; returns cycles from go edge to done
  task automatic run_op(input logic [7:0] a, b, c, x, output int lat);
    @(negedge clk);
    coef_a = a; coef_b = b; coef_c = c; x_in = x; go = 1'b1;
    @(posedge clk);
    @(negedge clk);
    go = 1'b0;
    x_in = ~x;                         // R6: late change must not matter
    lat = 1;
    while (!done && lat < 20) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int lat, cnt;
    logic [7:0] ra, rb, rc, rx;
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; go = 1'b0;
    x_in = '0; coef_a = '0; coef_b = '0; coef_c = '0;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && y_out == 8'd0, "R1 in reset", int'(y_out), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && y_out == 8'd0, "R1 after release", int'(y_out), 0);

    // table walk: R2 values, R3 latency and width, R6 late x change
    for (int i = 0; i < 10; i++) begin
      run_op(VEC[i].a, VEC[i].b, VEC[i].c, VEC[i].x, lat);
      check(y_out == VEC[i].e, "R2 table", int'(y_out), int'(VEC[i].e));
      check(lat == 5, "R3 latency", lat, 5);
      @(negedge clk);
      check(done == 1'b0, "R3 single pulse", int'(done), 0);
    end

    // random operands against the model (R2)
    for (int i = 0; i < 20; i++) begin
      ra = 8'($urandom); rb = 8'($urandom); rc = 8'($urandom); rx = 8'($urandom);
      run_op(ra, rb, rc, rx, lat);
      check(y_out == model(ra, rb, rc, rx), "R2 random", int'(y_out),
            int'(model(ra, rb, rc, rx)));
    end

    // R4: go during a run is ignored; R5: y holds afterwards
    @(negedge clk);
    coef_a = 8'd1; coef_b = 8'd2; coef_c = 8'd3; x_in = 8'd4; go = 1'b1;
    @(posedge clk); @(negedge clk);
    go = 1'b0; x_in = 8'd9;
    @(posedge clk); @(negedge clk);
    go = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    go = 1'b0;
    @(posedge clk); @(negedge clk);
    check(done == 1'b1, "R4 done on time", int'(done), 1);
    check(y_out == 8'd27, "R4 result unchanged", int'(y_out), 27);
    cnt = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done) cnt++;
    end
    check(cnt == 0, "R4 no extra result", cnt, 0);
    check(y_out == 8'd27, "R5 y held", int'(y_out), 27);

    // R7: go held high gives a result every five cycles
    @(negedge clk);
    coef_a = 8'd2; coef_b = 8'd3; coef_c = 8'd4; x_in = 8'd5; go = 1'b1;
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); @(negedge clk);
      if (done) begin
        cnt++;
        check(k % 5 == 4, "R7 pulse spacing", k, 4);
        check(y_out == 8'd69, "R7 result", int'(y_out), 69);
      end
    end
    go = 1'b0;
    check(cnt == 4, "R7 pulse count", cnt, 4);
    repeat (8) @(negedge clk);
    check(done == 1'b0 && y_out == 8'd69, "R5 idle hold", int'(y_out), 69);

    summary();
  end

endmodule